// File: doc/BRIEF.md
# Precise Pipeline Trap Controller

This block decides when a five-stage in-order pipeline takes an exception, and what state it leaves behind. Two stages can report a fault. The decode stage reports an unrecognised opcode, and the execute stage reports an arithmetic overflow. Each report arrives with the instruction's PC and a slot-valid bit. When a fault is accepted, the block does the following in the same cycle:

- It asserts the flushes for the pipeline registers at and behind the faulting instruction.
- It suppresses the register write of an overflowing instruction.
- It pulses a redirect strobe with the handler address for the fetch unit.

On the clock edge that closes that cycle, it latches the return PC (fault PC + 4) and a one-bit cause.

If both stages fault in one cycle, the older instruction in execute wins. Instructions already in memory and writeback are never flushed, so the trap stays precise. A mode input chooses between two handler entry schemes. One is a single shared handler entry. The other gives each cause its own entry, spaced 0x20 apart from a vector base. The cycle after a trap is taken, both fault inputs are masked. The flushed slots are bubbles by then, so one fault can never raise two traps.

Top module: `trap_ctrl`

## Requirements
- R1: While `rst_n` is low, the next edge clears `ret_pc_o` and `cause_o` to 0. All flush, write-kill and redirect outputs are held low while reset is asserted.
- R2: An execute overflow (`ex_ok_i`=1, `ex_ovf_i`=1) in a cycle that is not masked raises `kill_f_o`, `kill_d_o`, `kill_x_o`, `wr_block_o` and `jump_o` in that same cycle.
- R3: An undefined-opcode report from decode (`id_ok_i`=1, `id_bad_i`=1) that is accepted alone raises `kill_f_o`, `kill_d_o` and `jump_o`. It leaves `kill_x_o` and `wr_block_o` low.
- R4: When both stages report in the same cycle, the execute report wins. The recorded cause and PC are those of the execute instruction.
- R5: A fault flag whose stage valid bit is low has no effect. No output rises and the recorded state is unchanged.
- R6: On the edge ending a trap cycle, `ret_pc_o` becomes the winning instruction's PC plus 4. For example, an overflow at 0x0000_004C leaves 0x0000_0050.
- R7: On the same edge, `cause_o` becomes 0 for undefined opcode or 1 for overflow.
- R8: With `vec_mode_i`=0, `jump_pc_o` is 0x8000_0180 for every cause while `jump_o` is high.
- R9: With `vec_mode_i`=1, `jump_pc_o` is 0xC000_0000 for undefined opcode and 0xC000_0020 for overflow.
- R10: `jump_o` is a one-cycle pulse. In the cycle after a trap, all fault flags are ignored, even if they are still asserted. `jump_pc_o` reads 0 whenever `jump_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_mode_i | input | 1 | 0 = single handler entry, 1 = per-cause entries |
| id_ok_i | input | 1 | Decode slot holds a real instruction |
| id_bad_i | input | 1 | Decode found an undefined opcode |
| id_pc_i | input | 32 | PC of the decode instruction |
| ex_ok_i | input | 1 | Execute slot holds a real instruction |
| ex_ovf_i | input | 1 | Execute produced an arithmetic overflow |
| ex_pc_i | input | 32 | PC of the execute instruction |
| kill_f_o | output | 1 | Flush fetch-to-decode register |
| kill_d_o | output | 1 | Flush decode-to-execute register |
| kill_x_o | output | 1 | Flush execute-to-memory register |
| wr_block_o | output | 1 | Suppress the execute instruction's register write |
| ret_pc_o | output | 32 | Return PC latched at a trap (fault PC + 4) |
| cause_o | output | 1 | Latched trap cause (0 opcode, 1 overflow) |
| jump_o | output | 1 | One-cycle redirect strobe to fetch |
| jump_pc_o | output | 32 | Handler address for the redirect |

## Verification
The directed stimulus covers the following patterns:
- An overflow alone, which exposes the three-stage flush and the write kill.
- An undefined opcode alone, which shows that execute is spared.
- Both faults at once, which separates correct age priority from decode-first priority.
- Flags presented with their valid bits low, which shows whether the valid gating works.

A flag held for two cycles shows whether the post-trap mask stops a double take. Each pattern runs in both handler modes, which tells the shared entry from the per-cause vectors. A long pseudo-random run then compares every output against a behavioural model on every cycle.

// File: rtl/trap_pkg.sv
// Shared types for the trap controller.
// Assumes a 32-bit PC and exactly two fault sources.
package trap_pkg;
    localparam int XLEN = 32;

    typedef enum logic [0:0] {
        CAUSE_BADOP = 1'b0,
        CAUSE_OVF   = 1'b1
    } trap_cause_e;

    typedef struct packed {
        logic            hit;
        trap_cause_e     cause;
        logic [XLEN-1:0] pc;
        logic            from_ex;
    } trap_req_t;
endpackage

// File: rtl/trap_arbiter.sv
// Picks the winning fault by instruction age; execute is older than decode.
// Assumes flags are meaningful only when their slot valid bit is high and
// the mask input is low; it is purely combinational.
module trap_arbiter
    import trap_pkg::*;
(
    input  logic            mask_i,
    input  logic            id_ok_i,
    input  logic            id_bad_i,
    input  logic [XLEN-1:0] id_pc_i,
    input  logic            ex_ok_i,
    input  logic            ex_ovf_i,
    input  logic [XLEN-1:0] ex_pc_i,
    output trap_req_t       req_o
);
    logic ex_fault;
    logic id_fault;

    // Qualify each flag with its slot valid bit and the post-trap mask.
    always_comb begin
        ex_fault = ex_ok_i & ex_ovf_i & ~mask_i;
        id_fault = id_ok_i & id_bad_i & ~mask_i;
    end

    // Age priority: the execute instruction wins over the decode one.
    always_comb begin
        req_o.hit     = ex_fault | id_fault;
        req_o.from_ex = ex_fault;
        if (ex_fault) begin
            req_o.cause = CAUSE_OVF;
            req_o.pc    = ex_pc_i;
        end else begin
            req_o.cause = CAUSE_BADOP;
            req_o.pc    = id_pc_i;
        end
    end
endmodule

// File: rtl/trap_vector.sv
// Forms the handler address from the mode and the cause.
// Assumes causes are numbered from 0 and map to VEC_BASE + n*VEC_STRIDE.
module trap_vector
    import trap_pkg::*;
#(
    parameter logic [XLEN-1:0] FIXED_ENTRY = 32'h8000_0180,
    parameter logic [XLEN-1:0] VEC_BASE    = 32'hC000_0000,
    parameter logic [XLEN-1:0] VEC_STRIDE  = 32'h0000_0020,
    parameter int              N_VEC       = 2
) (
    input  logic            vec_mode_i,
    input  trap_cause_e     cause_i,
    output logic [XLEN-1:0] entry_o
);
    localparam int IDX_W = (N_VEC > 1) ? $clog2(N_VEC) : 1;

    logic [XLEN-1:0] vec_tab [N_VEC];
    logic [IDX_W-1:0] idx;

    // One table entry per cause, spaced by the stride.
    for (genvar g = 0; g < N_VEC; g++) begin : g_vec
        assign vec_tab[g] = VEC_BASE + VEC_STRIDE * g;
    end

    // Widen the cause to a table index.
    always_comb begin
        idx = IDX_W'(cause_i);
    end

    // Select the shared entry or the per-cause entry.
    always_comb begin
        if (vec_mode_i) entry_o = vec_tab[idx];
        else            entry_o = FIXED_ENTRY;
    end
endmodule

// File: rtl/trap_state.sv
// Holds the return PC, the cause and the one-cycle post-trap mask.
// Assumes a synchronous active-low reset; updates only on a taken trap.
module trap_state
    import trap_pkg::*;
#(
    parameter logic [XLEN-1:0] PC_STEP = 32'd4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  trap_req_t       req_i,
    output logic [XLEN-1:0] ret_pc_o,
    output trap_cause_e     cause_o,
    output logic            mask_o
);
    // Latch return PC and cause on the edge ending a trap cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_pc_o <= '0;
            cause_o  <= CAUSE_BADOP;
        end else if (req_i.hit) begin
            ret_pc_o <= req_i.pc + PC_STEP;
            cause_o  <= req_i.cause;
        end
    end

    // Mask all faults for the cycle right after a trap.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_o <= 1'b0;
        else        mask_o <= req_i.hit;
    end
endmodule

// File: rtl/trap_ctrl.sv
// Top of the precise trap controller: arbitration, handler address,
// flush/kill generation and recorded trap state.
// Assumes fault flags are presented combinationally in the cycle the
// instruction sits in its stage, and that the pipeline acts on flushes
// at the closing edge of that cycle.
module trap_ctrl
    import trap_pkg::*;
#(
    parameter logic [31:0] FIXED_ENTRY = 32'h8000_0180,
    parameter logic [31:0] VEC_BASE    = 32'hC000_0000,
    parameter logic [31:0] VEC_STRIDE  = 32'h0000_0020,
    parameter int          N_VEC       = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vec_mode_i,
    input  logic        id_ok_i,
    input  logic        id_bad_i,
    input  logic [31:0] id_pc_i,
    input  logic        ex_ok_i,
    input  logic        ex_ovf_i,
    input  logic [31:0] ex_pc_i,
    output logic        kill_f_o,
    output logic        kill_d_o,
    output logic        kill_x_o,
    output logic        wr_block_o,
    output logic [31:0] ret_pc_o,
    output logic        cause_o,
    output logic        jump_o,
    output logic [31:0] jump_pc_o
);
    trap_req_t   req_raw;
    trap_req_t   req;
    trap_cause_e cause_q;
    logic        mask_q;
    logic [31:0] entry;

    trap_arbiter u_arb (
        .mask_i   (mask_q),
        .id_ok_i  (id_ok_i),
        .id_bad_i (id_bad_i),
        .id_pc_i  (id_pc_i),
        .ex_ok_i  (ex_ok_i),
        .ex_ovf_i (ex_ovf_i),
        .ex_pc_i  (ex_pc_i),
        .req_o    (req_raw)
    );

    // Nothing is taken while reset is held.
    always_comb begin
        req     = req_raw;
        req.hit = req_raw.hit & rst_n;
        req.from_ex = req_raw.from_ex & rst_n;
    end

    trap_vector #(
        .FIXED_ENTRY (FIXED_ENTRY),
        .VEC_BASE    (VEC_BASE),
        .VEC_STRIDE  (VEC_STRIDE),
        .N_VEC       (N_VEC)
    ) u_vec (
        .vec_mode_i (vec_mode_i),
        .cause_i    (req.cause),
        .entry_o    (entry)
    );

    trap_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req),
        .ret_pc_o (ret_pc_o),
        .cause_o  (cause_q),
        .mask_o   (mask_q)
    );

    // Flush every slot at or younger than the winner; older stages run on.
    always_comb begin
        kill_f_o   = req.hit;
        kill_d_o   = req.hit;
        kill_x_o   = req.from_ex;
        wr_block_o = req.from_ex;
    end

    // Redirect strobe and address, address zero when idle.
    always_comb begin
        jump_o    = req.hit;
        jump_pc_o = req.hit ? entry : '0;
        cause_o   = cause_q;
    end
endmodule

// File: rtl/trap_ctrl_checker.sv
// Assertion checker for trap_ctrl, bound into every instance.
// Assumes it sees only the top-level ports.
module trap_ctrl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        vec_mode_i,
    input logic        id_ok_i,
    input logic        id_bad_i,
    input logic [31:0] id_pc_i,
    input logic        ex_ok_i,
    input logic        ex_ovf_i,
    input logic [31:0] ex_pc_i,
    input logic        kill_f_o,
    input logic        kill_d_o,
    input logic        kill_x_o,
    input logic        wr_block_o,
    input logic [31:0] ret_pc_o,
    input logic        cause_o,
    input logic        jump_o,
    input logic [31:0] jump_pc_o
);
    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        jump_o |=> !jump_o);

    p_ex_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_o && ex_ok_i && ex_ovf_i) |-> (kill_x_o && wr_block_o && kill_d_o && kill_f_o));

    p_id_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_o && !(ex_ok_i && ex_ovf_i)) |-> (kill_d_o && kill_f_o && !kill_x_o && !wr_block_o));

    p_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_ok_i && !id_ok_i) |-> (!jump_o && !kill_f_o && !kill_d_o && !kill_x_o));

    p_retpc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        jump_o |=> (ret_pc_o == ($past(kill_x_o) ? $past(ex_pc_i) : $past(id_pc_i)) + 32'd4));

    p_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        jump_o |=> (cause_o == $past(wr_block_o)));

    p_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_o && !vec_mode_i) |-> (jump_pc_o == 32'h8000_0180));

    p_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_o && vec_mode_i) |-> (jump_pc_o == (kill_x_o ? 32'hC000_0020 : 32'hC000_0000)));
endmodule

bind trap_ctrl trap_ctrl_checker u_chk (.*);

// File: tb/trap_ctrl_bench.sv
module trap_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vec_mode_i = 1'b0;
    logic        id_ok_i = 1'b0, id_bad_i = 1'b0;
    logic [31:0] id_pc_i = '0;
    logic        ex_ok_i = 1'b0, ex_ovf_i = 1'b0;
    logic [31:0] ex_pc_i = '0;
    logic        kill_f_o, kill_d_o, kill_x_o, wr_block_o, cause_o, jump_o;
    logic [31:0] ret_pc_o, jump_pc_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference state
    bit          m_mask = 0;
    logic [31:0] m_ret = '0;
    bit          m_cause = 0;

    always #5 clk = ~clk;

    trap_ctrl u_trap_ctrl (.*);

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare all outputs, advance the model.
    task automatic step(input bit rst, input bit vm,
                        input bit iok, input bit ibad, input logic [31:0] ipc,
                        input bit xok, input bit xovf, input logic [31:0] xpc,
                        input string tag);
        bit ex_hit, id_hit, take, c;
        logic [31:0] tgt, wpc;
        rst_n = ~rst; vec_mode_i = vm;
        id_ok_i = iok; id_bad_i = ibad; id_pc_i = ipc;
        ex_ok_i = xok; ex_ovf_i = xovf; ex_pc_i = xpc;
        #1;
        ex_hit = !rst && xok && xovf && !m_mask;
        id_hit = !rst && iok && ibad && !m_mask;
        take = ex_hit || id_hit;
        c = ex_hit;
        wpc = ex_hit ? xpc : ipc;
        tgt = !take ? 32'h0 : (vm ? (32'hC000_0000 + (c ? 32'h20 : 32'h0)) : 32'h8000_0180);
        chk(tag, "ret_pc", ret_pc_o, m_ret);
        chk(tag, "cause", {31'b0, cause_o}, {31'b0, m_cause});
        chk(tag, "kill_f", {31'b0, kill_f_o}, {31'b0, take});
        chk(tag, "kill_d", {31'b0, kill_d_o}, {31'b0, take});
        chk(tag, "kill_x", {31'b0, kill_x_o}, {31'b0, ex_hit});
        chk(tag, "wr_block", {31'b0, wr_block_o}, {31'b0, ex_hit});
        chk(tag, "jump", {31'b0, jump_o}, {31'b0, take});
        chk(tag, "jump_pc", jump_pc_o, tgt);
        @(posedge clk);
        if (rst) begin
            m_ret = '0; m_cause = 0; m_mask = 0;
        end else begin
            if (take) begin m_ret = wpc + 32'd4; m_cause = c; end
            m_mask = take;
        end
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset with faults presented, outputs held low, state cleared
        step(1, 0, 1, 1, 32'h10, 1, 1, 32'h14, "R1");
        step(1, 1, 1, 1, 32'h10, 1, 1, 32'h14, "R1");
        idle("R1");
        // R2 R6 R7 R8: overflow at 0x4C, fixed handler
        step(0, 0, 1, 0, 32'h50, 1, 1, 32'h4C, "R2_R8");
        idle("R6_R7");
        chk("R6", "ret_pc direct", ret_pc_o, 32'h50);
        // R3 R9: undefined opcode alone, vectored
        step(0, 1, 1, 1, 32'h200, 1, 0, 32'h1FC, "R3_R9");
        idle("R7");
        chk("R7", "cause direct", {31'b0, cause_o}, 32'h0);
        // R4 R9: both at once, execute wins
        step(0, 1, 1, 1, 32'h304, 1, 1, 32'h300, "R4_R9");
        idle("R4");
        chk("R4", "ret_pc direct", ret_pc_o, 32'h304);
        // R4 R8: both at once, fixed mode
        step(0, 0, 1, 1, 32'h404, 1, 1, 32'h400, "R4_R8");
        idle("R4");
        // R5: flags with valid low
        step(0, 0, 0, 1, 32'h500, 0, 1, 32'h4FC, "R5");
        step(0, 1, 0, 1, 32'h600, 0, 1, 32'h5FC, "R5");
        step(0, 1, 1, 0, 32'h700, 0, 1, 32'h6FC, "R5");
        chk("R5", "ret_pc unchanged", ret_pc_o, 32'h404);
        // R10: held flag taken once only
        step(0, 1, 0, 0, 0, 1, 1, 32'h800, "R10");
        step(0, 1, 0, 0, 0, 1, 1, 32'h800, "R10");
        step(0, 1, 1, 1, 32'h900, 0, 0, 0, "R3_R10");
        idle("R10");
        // Reset mid-run clears state (R1)
        step(1, 0, 0, 0, 0, 0, 0, 0, "R1");
        idle("R1");
        // Pseudo-random run against the model
        for (int i = 0; i < 2000; i++) begin
            step(($urandom % 50) == 0, $urandom % 2,
                 ($urandom % 4) != 0, ($urandom % 3) == 0, $urandom & 32'hFFFF_FFFC,
                 ($urandom % 4) != 0, ($urandom % 3) == 0, $urandom & 32'hFFFF_FFFC,
                 "R2_R3_R4_R5_R10");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule